// File: doc/BRIEF.md
# Digital PLL Timing-Mode Controller with Frequency History

This block decides how the numerically controlled oscillator of a digital PLL is steered. Four timing references feed the loop, and each one carries a quality bit from an outside monitor. A programmed mode code selects the behaviour. In tracking the oscillator follows the loop's frequency word. In holdover it keeps a frozen word. In freerun it uses a fixed nominal word. An automatic mode switches between tracking and holdover by itself. Software can also force one reference or name one as preferred.

While tracking, the block keeps a small circular record of the loop's frequency word, sampled every few clock cycles. A failing reference pulls the loop off frequency before the monitor flags it. For that reason holdover entry takes a recorded word that is a programmable number of samples older than the newest. The word tracked during the doubtful period is not used.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: While the hardware reset `rstN` is low, `ncoWord` equals `NOMINAL_WORD`, `holdFlag` is 0 and `activeRef` is 0. All recorded words are `NOMINAL_WORD`, and the sample counter and write pointer are 0.
- R2: In mode code 0 (tracking), `holdFlag` is 0 one cycle later. `ncoWord` then equals the `loopFreq` value present at the previous rising edge.
- R3: While the block tracks, it picks `activeRef` in this order: `forceRef` when `forceEn` is 1; otherwise `prefRef` when `prefEn` is 1 and that reference is valid; otherwise the lowest-index valid reference. In mode 0 with no force and no valid reference, `activeRef` keeps its value.
- R4: In mode code 1 (holdover), `holdFlag` is 1 one cycle later. While the block stays in holdover, `ncoWord` and `activeRef` do not change.
- R5: A sample counter counts clock cycles modulo `SAMPLE_PERIOD`. At the edge where it wraps, `loopFreq` is written into the next slot of an 8-entry circular record, but only if the block was tracking before that edge. In holdover and freerun the record does not change.
- R6: On the edge that enters holdover from any other state, `ncoWord` takes the recorded word that is `holdAge` samples older than the newest word written before that edge. A `holdAge` of 0 selects the newest word.
- R7: In mode code 2 (automatic), the block tracks when a usable reference exists and holds otherwise. With `forceEn` at 1, usable means `refValid[forceRef]` is 1. With `forceEn` at 0, usable means any bit of `refValid` is 1. The block returns to tracking as soon as a reference becomes usable again.
- R8: In mode code 3 (freerun), and in the unused codes 5 to 7, `ncoWord` is `NOMINAL_WORD` and `holdFlag` is 0 one cycle later. The record is left untouched.
- R9: In mode code 4 (internal reset), the record is reset to `NOMINAL_WORD` and the write pointer and sample counter are cleared. The output behaves as in freerun until another mode is programmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| modeSel | input | 3 | Timing mode code (0 track, 1 holdover, 2 automatic, 3 freerun, 4 internal reset) |
| forceEn | input | 1 | Force locking to `forceRef` |
| forceRef | input | REF_W | Forced reference index |
| prefEn | input | 1 | Enable the preferred reference |
| prefRef | input | REF_W | Preferred reference index |
| refValid | input | NUM_REF | Per-reference quality flag, 1 = usable |
| loopFreq | input | FREQ_W | Frequency word from the loop filter |
| holdAge | input | AGE_W | Age in samples of the word restored on holdover entry |
| activeRef | output | REF_W | Index of the reference the loop follows |
| holdFlag | output | 1 | 1 while the block is in holdover |
| ncoWord | output | FREQ_W | Frequency word for the oscillator |

## Verification
The bench ramps `loopFreq` by one each cycle, so every recorded word shows the edge at which it was taken. Holdover is entered exactly on a write edge and one cycle after one. A design that exposes the word written on the same edge restores a value four counts too new. The bench uses ages that reach back across the wrap of the circular record; wrong pointer arithmetic returns a fresh or stale word. A freerun stretch between tracking and holdover catches a record that keeps sampling outside tracking. A tracking period that starts right after internal reset catches a sample counter that was never cleared, because the first write then lands one cycle off. The reference table covers an invalid preferred reference, a forced reference that is not valid in automatic mode, and a revertive switch to a preferred reference that becomes valid again.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  localparam logic [2:0] MODE_TRACK    = 3'd0;
  localparam logic [2:0] MODE_HOLDOVER = 3'd1;
  localparam logic [2:0] MODE_AUTO     = 3'd2;
  localparam logic [2:0] MODE_FREERUN  = 3'd3;
  localparam logic [2:0] MODE_INTRST   = 3'd4;

  typedef enum logic [1:0] {
    ST_FREE  = 2'd0,
    ST_TRACK = 2'd1,
    ST_HOLD  = 2'd2
  } loopState_t;

  typedef struct packed {
    logic       sampleOn;
    logic       clearHist;
    logic       captureHold;
    loopState_t nextState;
  } dpStrobe_t;

endpackage

// File: rtl/dmc_control.sv
module dmc_control
  import dmc_pkg::*;
#(
  parameter int NUM_REF = 4,
  parameter int REF_W   = $clog2(NUM_REF)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         modeSel,
  input  logic               forceEn,
  input  logic [REF_W-1:0]   forceRef,
  input  logic               prefEn,
  input  logic [REF_W-1:0]   prefRef,
  input  logic [NUM_REF-1:0] refValid,
  output logic [REF_W-1:0]   activeRef,
  output logic               holdFlag,
  output dpStrobe_t          strobe
);

  loopState_t       curState;
  loopState_t       nextState;
  logic [REF_W-1:0] lowestIdx;
  logic             anyValid;
  logic             prefOk;
  logic [REF_W-1:0] autoPick;
  logic [REF_W-1:0] pick;
  logic             pickOk;
  logic [REF_W-1:0] nextRef;

  // lowest-index valid reference
  always_comb begin
    lowestIdx = '0;
    for (int i = NUM_REF - 1; i >= 0; i--) begin
      if (refValid[i]) lowestIdx = REF_W'(i);
    end
  end

  assign anyValid = |refValid;
  assign prefOk   = prefEn && refValid[prefRef];
  assign autoPick = prefOk ? prefRef : lowestIdx;
  assign pick     = forceEn ? forceRef : autoPick;
  assign pickOk   = forceEn ? refValid[forceRef] : anyValid;

  always_comb begin
    nextState = curState;
    nextRef   = activeRef;
    case (modeSel)
      MODE_TRACK: begin
        nextState = ST_TRACK;
        if (forceEn)       nextRef = forceRef;
        else if (anyValid) nextRef = autoPick;
      end
      MODE_HOLDOVER: begin
        nextState = ST_HOLD;
      end
      MODE_AUTO: begin
        if (pickOk) begin
          nextState = ST_TRACK;
          nextRef   = pick;
        end else begin
          nextState = ST_HOLD;
        end
      end
      default: begin
        nextState = ST_FREE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState  <= ST_FREE;
      activeRef <= '0;
    end else begin
      curState  <= nextState;
      activeRef <= nextRef;
    end
  end

  assign holdFlag = (curState == ST_HOLD);

  always_comb begin
    strobe.nextState   = nextState;
    strobe.clearHist   = (modeSel == MODE_INTRST);
    strobe.sampleOn    = (curState == ST_TRACK);
    strobe.captureHold = (nextState == ST_HOLD) && (curState != ST_HOLD);
  end

endmodule

// File: rtl/dmc_datapath.sv
module dmc_datapath
  import dmc_pkg::*;
#(
  parameter int                FREQ_W        = 24,
  parameter int                HIST_DEPTH    = 8,
  parameter int                SAMPLE_PERIOD = 1024,
  parameter logic [FREQ_W-1:0] NOMINAL_WORD  = {1'b1, {(FREQ_W-1){1'b0}}},
  parameter int                AGE_W         = $clog2(HIST_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [FREQ_W-1:0] loopFreq,
  input  logic [AGE_W-1:0]  holdAge,
  output logic [FREQ_W-1:0] ncoWord
);

  localparam int CNT_W = (SAMPLE_PERIOD > 1) ? $clog2(SAMPLE_PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_PERIOD - 1);

  logic [CNT_W-1:0]      sampleCnt;
  logic                  sampleTick;
  logic                  writeNow;
  logic [AGE_W-1:0]      wrPtr;
  logic [AGE_W-1:0]      rdIdx;
  logic [HIST_DEPTH-1:0] entryWe;
  logic [FREQ_W-1:0]     hist [HIST_DEPTH];
  logic [FREQ_W-1:0]     histRd;

  assign sampleTick = (sampleCnt == CNT_LAST);
  assign writeNow   = sampleTick && strobe.sampleOn && !strobe.clearHist;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sampleCnt <= '0;
    else if (strobe.clearHist) sampleCnt <= '0;
    else if (sampleTick)       sampleCnt <= '0;
    else                       sampleCnt <= sampleCnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 wrPtr <= '0;
    else if (strobe.clearHist) wrPtr <= '0;
    else if (writeNow)         wrPtr <= wrPtr + AGE_W'(1);
  end

  for (genvar g = 0; g < HIST_DEPTH; g++) begin : g_we
    assign entryWe[g] = writeNow && (wrPtr == AGE_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < HIST_DEPTH; i++) hist[i] <= NOMINAL_WORD;
    end else begin
      for (int i = 0; i < HIST_DEPTH; i++) begin
        if (strobe.clearHist) hist[i] <= NOMINAL_WORD;
        else if (entryWe[i])  hist[i] <= loopFreq;
      end
    end
  end

  // newest entry sits one below the write pointer; step back by holdAge
  assign rdIdx  = wrPtr - AGE_W'(1) - holdAge;
  assign histRd = hist[rdIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ncoWord <= NOMINAL_WORD;
    end else begin
      case (strobe.nextState)
        ST_TRACK: ncoWord <= loopFreq;
        ST_HOLD:  if (strobe.captureHold) ncoWord <= histRd;
        default:  ncoWord <= NOMINAL_WORD;
      endcase
    end
  end

endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
  import dmc_pkg::*;
#(
  parameter int                NUM_REF       = 4,
  parameter int                FREQ_W        = 24,
  parameter int                HIST_DEPTH    = 8,
  parameter int                SAMPLE_PERIOD = 1024,
  parameter logic [FREQ_W-1:0] NOMINAL_WORD  = {1'b1, {(FREQ_W-1){1'b0}}},
  parameter int                REF_W         = $clog2(NUM_REF),
  parameter int                AGE_W         = $clog2(HIST_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         modeSel,
  input  logic               forceEn,
  input  logic [REF_W-1:0]   forceRef,
  input  logic               prefEn,
  input  logic [REF_W-1:0]   prefRef,
  input  logic [NUM_REF-1:0] refValid,
  input  logic [FREQ_W-1:0]  loopFreq,
  input  logic [AGE_W-1:0]   holdAge,
  output logic [REF_W-1:0]   activeRef,
  output logic               holdFlag,
  output logic [FREQ_W-1:0]  ncoWord
);

  dpStrobe_t strobe;

  dmc_control #(
    .NUM_REF (NUM_REF),
    .REF_W   (REF_W)
  ) control_i (
    .clk       (clk),
    .rstN      (rstN),
    .modeSel   (modeSel),
    .forceEn   (forceEn),
    .forceRef  (forceRef),
    .prefEn    (prefEn),
    .prefRef   (prefRef),
    .refValid  (refValid),
    .activeRef (activeRef),
    .holdFlag  (holdFlag),
    .strobe    (strobe)
  );

  dmc_datapath #(
    .FREQ_W        (FREQ_W),
    .HIST_DEPTH    (HIST_DEPTH),
    .SAMPLE_PERIOD (SAMPLE_PERIOD),
    .NOMINAL_WORD  (NOMINAL_WORD),
    .AGE_W         (AGE_W)
  ) datapath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .loopFreq (loopFreq),
    .holdAge  (holdAge),
    .ncoWord  (ncoWord)
  );

endmodule

// File: rtl/dmc_checker.sv
module dmc_checker
  import dmc_pkg::*;
#(
  parameter int                NUM_REF      = 4,
  parameter int                FREQ_W       = 24,
  parameter logic [FREQ_W-1:0] NOMINAL_WORD = {1'b1, {(FREQ_W-1){1'b0}}},
  parameter int                REF_W        = $clog2(NUM_REF)
) (
  input logic               clk,
  input logic               rstN,
  input logic [2:0]         modeSel,
  input logic               forceEn,
  input logic [REF_W-1:0]   forceRef,
  input logic [NUM_REF-1:0] refValid,
  input logic [FREQ_W-1:0]  loopFreq,
  input logic [REF_W-1:0]   activeRef,
  input logic               holdFlag,
  input logic [FREQ_W-1:0]  ncoWord
);

  assert_track_passthru_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_TRACK) |=> (!holdFlag && ncoWord == $past(loopFreq)));

  assert_forced_ref_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_TRACK && forceEn) |=> (activeRef == $past(forceRef)));

  assert_hold_mode_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_HOLDOVER) |=> holdFlag);

  assert_hold_frozen_R4: assert property (@(posedge clk) disable iff (!rstN)
    (holdFlag && $past(holdFlag)) |-> ($stable(ncoWord) && $stable(activeRef)));

  assert_auto_noref_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_AUTO && !forceEn && refValid == '0) |=> holdFlag);

  assert_auto_track_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_AUTO && !forceEn && refValid != '0) |=> !holdFlag);

  assert_freerun_word_R8: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_FREERUN) |=> (ncoWord == NOMINAL_WORD && !holdFlag));

  assert_intrst_word_R9: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_INTRST) |=> (ncoWord == NOMINAL_WORD && !holdFlag));

endmodule

bind dpll_mode_ctrl dmc_checker #(
  .NUM_REF      (NUM_REF),
  .FREQ_W       (FREQ_W),
  .NOMINAL_WORD (NOMINAL_WORD),
  .REF_W        (REF_W)
) checker_i (
  .clk       (clk),
  .rstN      (rstN),
  .modeSel   (modeSel),
  .forceEn   (forceEn),
  .forceRef  (forceRef),
  .refValid  (refValid),
  .loopFreq  (loopFreq),
  .activeRef (activeRef),
  .holdFlag  (holdFlag),
  .ncoWord   (ncoWord)
);

// File: tb/dpll_mode_ctrl_tb_top.sv
module dpll_mode_ctrl_tb_top;
  import dmc_pkg::*;

  localparam int          FREQ_W  = 16;
  localparam int          PERIOD  = 4;
  localparam logic [15:0] NOMINAL = 16'h8000;
  localparam logic [15:0] BASE    = 16'h1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  modeSel = MODE_TRACK;
  logic        forceEn = 1'b0;
  logic [1:0]  forceRef = '0;
  logic        prefEn = 1'b0;
  logic [1:0]  prefRef = '0;
  logic [3:0]  refValid = 4'b1111;
  logic [15:0] loopFreq = BASE;
  logic [2:0]  holdAge = '0;
  logic [1:0]  activeRef;
  logic        holdFlag;
  logic [15:0] ncoWord;

  int checkCount = 0;
  int failCount  = 0;
  int edgeCnt    = 0;
  int cycles     = 0;

  always #4 clk = ~clk;

  dpll_mode_ctrl #(
    .NUM_REF       (4),
    .FREQ_W        (FREQ_W),
    .HIST_DEPTH    (8),
    .SAMPLE_PERIOD (PERIOD),
    .NOMINAL_WORD  (NOMINAL)
  ) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .modeSel   (modeSel),
    .forceEn   (forceEn),
    .forceRef  (forceRef),
    .prefEn    (prefEn),
    .prefRef   (prefRef),
    .refValid  (refValid),
    .loopFreq  (loopFreq),
    .holdAge   (holdAge),
    .activeRef (activeRef),
    .holdFlag  (holdFlag),
    .ncoWord   (ncoWord)
  );

  typedef struct packed {
    logic [2:0] mode;
    logic [3:0] valid;
    logic       fEn;
    logic [1:0] fRef;
    logic       pEn;
    logic [1:0] pRef;
    logic [1:0] expRef;
    logic       expHold;
    logic       expNom;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 4'b1111, 1'b0, 2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0}, // R3 lowest valid
    '{3'd0, 4'b1100, 1'b0, 2'd0, 1'b0, 2'd0, 2'd2, 1'b0, 1'b0}, // R3 lowest valid
    '{3'd0, 4'b1111, 1'b0, 2'd0, 1'b1, 2'd3, 2'd3, 1'b0, 1'b0}, // R3 preferred
    '{3'd0, 4'b0111, 1'b0, 2'd0, 1'b1, 2'd3, 2'd0, 1'b0, 1'b0}, // R3 preferred invalid
    '{3'd0, 4'b0000, 1'b0, 2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0}, // R3 none valid keeps
    '{3'd0, 4'b0000, 1'b1, 2'd1, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0}, // R3 forced
    '{3'd0, 4'b0000, 1'b0, 2'd0, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0}, // R3 keeps
    '{3'd1, 4'b1111, 1'b0, 2'd0, 1'b0, 2'd0, 2'd1, 1'b1, 1'b0}, // R4 holdover
    '{3'd2, 4'b1000, 1'b0, 2'd0, 1'b0, 2'd0, 2'd3, 1'b0, 1'b0}, // R7 auto track
    '{3'd2, 4'b0000, 1'b0, 2'd0, 1'b0, 2'd0, 2'd3, 1'b1, 1'b0}, // R7 auto hold
    '{3'd2, 4'b0110, 1'b0, 2'd0, 1'b1, 2'd2, 2'd2, 1'b0, 1'b0}, // R7 return, preferred
    '{3'd2, 4'b0110, 1'b1, 2'd0, 1'b0, 2'd0, 2'd2, 1'b1, 1'b0}, // R7 forced invalid
    '{3'd2, 4'b0110, 1'b1, 2'd1, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0}, // R7 forced valid
    '{3'd3, 4'b1111, 1'b0, 2'd0, 1'b0, 2'd0, 2'd1, 1'b0, 1'b1}, // R8 freerun
    '{3'd6, 4'b1111, 1'b0, 2'd0, 1'b0, 2'd0, 2'd1, 1'b0, 1'b1}, // R8 unused code
    '{3'd4, 4'b1111, 1'b0, 2'd0, 1'b0, 2'd0, 2'd1, 1'b0, 1'b1}, // R9 internal reset
    '{3'd2, 4'b0100, 1'b0, 2'd0, 1'b1, 2'd0, 2'd2, 1'b0, 1'b0}, // R7 preferred invalid
    '{3'd2, 4'b1100, 1'b0, 2'd0, 1'b1, 2'd3, 2'd3, 1'b0, 1'b0}  // R7 revert to preferred
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    edgeCnt++;
    loopFreq = BASE + 16'(edgeCnt + 1);
  endtask

  task automatic tickN(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic doReset();
    rstN = 1'b0;
    modeSel = MODE_TRACK; forceEn = 1'b0; prefEn = 1'b0;
    refValid = 4'b1111; holdAge = '0;
    @(posedge clk); #2;
    @(posedge clk); #2;
    rstN = 1'b1;
    edgeCnt = 0;
    loopFreq = BASE + 16'd1;
  endtask

  function automatic logic [15:0] histExpect(input int h, input int k);
    int m;
    m = (h - 1) / PERIOD - k;
    return (m >= 1) ? BASE + 16'(m * PERIOD) : NOMINAL;
  endfunction

  task automatic histTest(input int k, input int h);
    doReset();
    holdAge = 3'(k);
    tickN(h - 1);
    chk("R2 tracking pass-through", 32'(ncoWord), 32'(BASE + 16'(edgeCnt)));
    modeSel = MODE_AUTO; refValid = 4'b0000;
    tick();
    chk("R6 holdover restore", 32'(ncoWord), 32'(histExpect(h, k)));
    chk("R7 holdover on lost refs", 32'(holdFlag), 32'd1);
  endtask

  task automatic irstTest(input int k, input logic [15:0] exp);
    doReset();
    holdAge = 3'(k);
    tickN(20);
    modeSel = MODE_INTRST;
    tickN(3);
    chk("R9 nominal in internal reset", 32'(ncoWord), 32'(NOMINAL));
    modeSel = MODE_TRACK;
    tickN(5);
    modeSel = MODE_AUTO; refValid = 4'b0000;
    tick();
    chk("R9 history and counter cleared", 32'(ncoWord), 32'(exp));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    rstN = 1'b0;
    #10;
    chk("R1 reset ncoWord", 32'(ncoWord), 32'(NOMINAL));
    chk("R1 reset holdFlag", 32'(holdFlag), 32'd0);
    chk("R1 reset activeRef", 32'(activeRef), 32'd0);
    doReset();

    for (int v = 0; v < NVEC; v++) begin
      modeSel = VECS[v].mode; refValid = VECS[v].valid;
      forceEn = VECS[v].fEn; forceRef = VECS[v].fRef;
      prefEn = VECS[v].pEn; prefRef = VECS[v].pRef;
      tick();
      chk($sformatf("R3/R4/R7/R8/R9 vector %0d activeRef", v), 32'(activeRef), 32'(VECS[v].expRef));
      chk($sformatf("R4/R7/R8 vector %0d holdFlag", v), 32'(holdFlag), 32'(VECS[v].expHold));
      if (VECS[v].expNom)
        chk($sformatf("R8/R9 vector %0d ncoWord", v), 32'(ncoWord), 32'(NOMINAL));
    end

    // R6 ages across the wrap and on write-edge boundaries
    histTest(3, 42);
    held = ncoWord;
    tickN(4);
    chk("R4 hold word frozen", 32'(ncoWord), 32'(held));
    refValid = 4'b0010;
    tick();
    chk("R7 return to tracking", 32'(holdFlag), 32'd0);
    chk("R7 return picks valid ref", 32'(activeRef), 32'd1);
    chk("R2 tracking after return", 32'(ncoWord), 32'(BASE + 16'(edgeCnt)));
    histTest(7, 42);
    histTest(0, 41);
    histTest(0, 40);
    histTest(3, 6);

    // R5/R8: record frozen during freerun
    doReset();
    tickN(20);
    modeSel = MODE_FREERUN;
    tickN(12);
    chk("R8 freerun nominal", 32'(ncoWord), 32'(NOMINAL));
    chk("R8 freerun no hold", 32'(holdFlag), 32'd0);
    modeSel = MODE_AUTO; refValid = 4'b0000;
    tick();
    chk("R5 record frozen in freerun", 32'(ncoWord), 32'(BASE + 16'd20));

    // R9: counter restart and cleared history
    irstTest(0, BASE + 16'd27);
    irstTest(1, NOMINAL);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule